// File: doc/BRIEF.md
# Breaker-Failure Timer with Trip Extension

This block times a breaker-failure condition for breakers that may receive only a short trip pulse. A trip request must be held across a programmable number of consecutive sample strobes (one quarter cycle of the power system). Once it qualifies, the request is captured and stretched by a programmable extension, so the trip stays visible after the input pulse has gone. While the stretched trip is present, a failure timer counts sample strobes. Once started, it keeps counting while either the stretched trip or the overcurrent-picked-up bit is high. It clears only when both are low.

When the count reaches its setting, the breaker-failure output rises and stays high until the timer clears. Because the timer is held by the stretched trip and not only by the current detector, a trip that arrives before the fault current crosses its threshold still produces a correct failure time. That case occurs when an adjacent breaker must clear first. All state moves only on the sample strobe, and a synchronous reset clears it. Current measurement is done upstream. The block sees only the picked-up bit.

Top module: `bfx_breaker_fail`

## Requirements
- R1: The trip request qualifies only after it has been sampled high on QTR_SMP consecutive strobes. A low sample restarts the count. A pulse shorter than QTR_SMP strobes leaves `trip_ext` and the timer low.
- R2: `trip_ext` is high from the strobe on which the request qualifies, and stays high for as long as the qualified request holds.
- R3: On the strobe after qualification, the extension counter is loaded with `ext_set` (nonzero). `trip_ext` stays high until `ext_set` further strobes have passed after that capture strobe, even if `trip_in` has dropped.
- R4: With `ext_set` equal to zero there is no extension. `trip_ext` falls on the first strobe that samples `trip_in` low.
- R5: A new qualification rising edge during an active extension reloads the counter with `ext_set`.
- R6: The failure timer starts on any strobe that sees `trip_ext` high, whether or not `oc_pick` is high. `oc_pick` alone never starts it. `bf_timing` is high while the count is nonzero.
- R7: A running timer keeps counting while `trip_ext` or `oc_pick` is high. It clears, together with `bf_out`, on the first strobe that sees both low.
- R8: The first running strobe counts 1. `bf_out` rises on the strobe where the count reaches `bf_set`. A setting of 0 behaves like 1.
- R9: `bf_out` stays high until the timer clears. The count saturates at 2^BF_W-1 and does not wrap.
- R10: Outputs change only on clock edges where `smp_stb` is high, or on reset. A synchronous `rst` clears all state and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe; all timing advances on it |
| trip_in | input | 1 | Trip request |
| oc_pick | input | 1 | Overcurrent picked-up bit |
| ext_set | input | EXT_W | Trip extension, in strobes (0 = none) |
| bf_set | input | BF_W | Failure timer setting, in strobes |
| trip_ext | output | 1 | Qualified and extended trip |
| bf_timing | output | 1 | Failure timer running |
| bf_out | output | 1 | Breaker-failure output |

## Verification
The bench builds the block with QTR_SMP=3, EXT_W=4 and BF_W=5. The short qualification window lets sub-window pulses and back-to-back requalification fit into a few strobes. A 31-strobe counter ceiling brings saturation within reach of a 40-strobe run, where a wrapping count would drop an overcurrent-held timer. Small extension values let a single sequence cover both orders of trip and overcurrent, extension expiry ahead of current dropout, and reload during an active extension.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  // Saturating increment on an unsigned count.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned vmax);
    return (v >= vmax) ? vmax : v + 1;
  endfunction

  // Decrement that stops at zero.
  function automatic int unsigned dec_floor(input int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/bfx_trip_qual.sv
module bfx_trip_qual #(
  parameter int QTR_SMP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_stb,
  input  logic trip_in,
  output logic trip_q,
  output logic q_rise
);
  localparam int QW = $clog2(QTR_SMP + 1);
  localparam int unsigned QMAX = QTR_SMP;

  logic [QW-1:0] hold_cnt;
  logic          q_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      q_prev   <= 1'b0;
    end else if (smp_stb) begin
      hold_cnt <= trip_in ? QW'(bfx_pkg::sat_inc(32'(hold_cnt), QMAX)) : '0;
      q_prev   <= trip_q;
    end
  end

  assign trip_q = (hold_cnt == QW'(QMAX));
  assign q_rise = trip_q & ~q_prev;
endmodule

// File: rtl/bfx_trip_ext.sv
module bfx_trip_ext #(
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic             trip_q,
  input  logic             q_rise,
  input  logic [EXT_W-1:0] ext_set,
  output logic             cap_evt,
  output logic             trip_ext
);
  logic [EXT_W-1:0] ext_cnt;

  assign cap_evt = smp_stb & q_rise & (ext_set != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_cnt <= '0;
    end else if (cap_evt) begin
      ext_cnt <= ext_set;
    end else if (smp_stb) begin
      ext_cnt <= EXT_W'(bfx_pkg::dec_floor(32'(ext_cnt)));
    end
  end

  assign trip_ext = trip_q | (ext_cnt != '0);
endmodule

// File: rtl/bfx_fail_timer.sv
module bfx_fail_timer #(
  parameter int BF_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_stb,
  input  logic            trip_ext,
  input  logic            oc_pick,
  input  logic [BF_W-1:0] bf_set,
  output logic            run_cond,
  output logic            bf_timing,
  output logic            bf_out
);
  localparam int unsigned BF_MAX = (1 << BF_W) - 1;

  logic [BF_W-1:0] bf_cnt;
  logic [BF_W-1:0] bf_nxt;

  assign bf_timing = (bf_cnt != '0);
  assign run_cond  = trip_ext | (oc_pick & bf_timing);
  assign bf_nxt    = BF_W'(bfx_pkg::sat_inc(32'(bf_cnt), BF_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      bf_cnt <= '0;
      bf_out <= 1'b0;
    end else if (smp_stb) begin
      if (run_cond) begin
        bf_cnt <= bf_nxt;
        bf_out <= bf_out | (bf_nxt >= bf_set);
      end else begin
        bf_cnt <= '0;
        bf_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfx_breaker_fail.sv
module bfx_breaker_fail #(
  parameter int QTR_SMP = 4,
  parameter int EXT_W   = 8,
  parameter int BF_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic             trip_in,
  input  logic             oc_pick,
  input  logic [EXT_W-1:0] ext_set,
  input  logic [BF_W-1:0]  bf_set,
  output logic             trip_ext,
  output logic             bf_timing,
  output logic             bf_out
);
  logic trip_q;
  logic q_rise;
  logic cap_evt;
  logic run_cond;

  bfx_trip_qual #(.QTR_SMP(QTR_SMP)) u_qual (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .trip_in(trip_in),
    .trip_q(trip_q), .q_rise(q_rise)
  );

  bfx_trip_ext #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .trip_q(trip_q),
    .q_rise(q_rise), .ext_set(ext_set), .cap_evt(cap_evt),
    .trip_ext(trip_ext)
  );

  bfx_fail_timer #(.BF_W(BF_W)) u_timer (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .trip_ext(trip_ext),
    .oc_pick(oc_pick), .bf_set(bf_set), .run_cond(run_cond),
    .bf_timing(bf_timing), .bf_out(bf_out)
  );
endmodule

// File: rtl/bfx_breaker_fail_chk.sv
module bfx_breaker_fail_chk (
  input logic clk,
  input logic rst,
  input logic smp_stb,
  input logic trip_in,
  input logic oc_pick,
  input logic trip_q,
  input logic cap_evt,
  input logic run_cond,
  input logic trip_ext,
  input logic bf_timing,
  input logic bf_out
);
  AST_SHORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    smp_stb && !trip_in |=> !trip_q); // R1
  AST_QUAL_DRIVES_EXT: assert property (@(posedge clk) disable iff (rst)
    trip_q |-> trip_ext); // R2
  AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> trip_ext); // R3
  AST_TIMER_START: assert property (@(posedge clk) disable iff (rst)
    smp_stb && trip_ext |=> bf_timing); // R6
  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    smp_stb && !trip_ext && !oc_pick |=> !bf_timing && !bf_out); // R7
  AST_BF_STICKY: assert property (@(posedge clk) disable iff (rst)
    smp_stb && bf_out && run_cond |=> bf_out); // R9
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(trip_ext) && $stable(bf_timing) && $stable(bf_out)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !trip_ext && !bf_timing && !bf_out); // R10
endmodule

bind bfx_breaker_fail bfx_breaker_fail_chk u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .trip_in(trip_in),
  .oc_pick(oc_pick), .trip_q(trip_q), .cap_evt(cap_evt),
  .run_cond(run_cond), .trip_ext(trip_ext), .bf_timing(bf_timing),
  .bf_out(bf_out)
);

// File: tb/bfx_breaker_fail_tb.sv
module bfx_breaker_fail_tb;
  localparam int QTR   = 3;
  localparam int EXT_W = 4;
  localparam int BF_W  = 5;
  localparam int BFMAX = (1 << BF_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic trip_in = 1'b0;
  logic oc_pick = 1'b0;
  logic [EXT_W-1:0] ext_set = '0;
  logic [BF_W-1:0]  bf_set = '0;
  logic trip_ext, bf_timing, bf_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  int  m_q = 0;
  bit  m_qd = 0;
  int  m_ext = 0;
  int  m_bf = 0;
  bit  m_bo = 0;

  always #10 clk = ~clk;

  bfx_breaker_fail #(.QTR_SMP(QTR), .EXT_W(EXT_W), .BF_W(BF_W)) u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .trip_in(trip_in),
    .oc_pick(oc_pick), .ext_set(ext_set), .bf_set(bf_set),
    .trip_ext(trip_ext), .bf_timing(bf_timing), .bf_out(bf_out)
  );

  // rows: trip start, trip len, oc start, oc len, ext, bf, steps
  localparam int NROW = 7;
  localparam int TBL [NROW][7] = '{
    '{0, 4,  6, 10, 5, 12, 22},
    '{2, 3,  0, 20, 2,  8, 24},
    '{1, 2,  0,  8, 6,  3, 10},
    '{0, 3, 99,  0, 7, 20, 14},
    '{0, 5, 99,  0, 0,  2,  9},
    '{0, 3, 99,  0, 1,  0,  8},
    '{0, 3,  2, 12, 2,  9, 18}
  };

  function automatic string row_tag(input int r);
    case (r)
      0: return "R7";
      1: return "R6";
      2: return "R1";
      3: return "R3";
      4: return "R4";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "trip_ext", trip_ext, (m_q >= QTR) || (m_ext > 0));
    check(tag, "bf_timing", bf_timing, m_bf > 0);
    check(tag, "bf_out", bf_out, m_bo);
  endtask

  task automatic model_reset();
    m_q = 0; m_qd = 0; m_ext = 0; m_bf = 0; m_bo = 0;
  endtask

  // Reference from the requirements, evaluated on pre-strobe state.
  task automatic model_strobe(input bit t, input bit o);
    bit qual, te, run, rise;
    qual = (m_q >= QTR);
    te   = qual || (m_ext > 0);
    run  = te || (o && (m_bf > 0));
    rise = qual && !m_qd;
    m_q  = t ? ((m_q < QTR) ? m_q + 1 : QTR) : 0;
    m_qd = qual;
    if (rise && ext_set != 0) m_ext = int'(ext_set);
    else if (m_ext > 0)       m_ext = m_ext - 1;
    if (run) begin
      m_bf = (m_bf < BFMAX) ? m_bf + 1 : BFMAX;
      m_bo = m_bo || (m_bf >= int'(bf_set));
    end else begin
      m_bf = 0;
      m_bo = 0;
    end
  endtask

  task automatic step(input bit t, input bit o, input string tag);
    @(negedge clk);
    trip_in = t; oc_pick = o; smp_stb = 1'b1;
    model_strobe(t, o);
    @(negedge clk);
    smp_stb = 1'b0;
    compare(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; trip_in = 1'b0; oc_pick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    compare("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // table walk
    for (int r = 0; r < NROW; r++) begin
      ext_set = EXT_W'(TBL[r][4]);
      bf_set  = BF_W'(TBL[r][5]);
      do_reset();
      for (int i = 0; i < TBL[r][6]; i++) begin
        step((i >= TBL[r][0]) && (i < TBL[r][0] + TBL[r][1]),
             (i >= TBL[r][2]) && (i < TBL[r][2] + TBL[r][3]), row_tag(r));
      end
    end

    // R2: held request keeps trip_ext high without extension
    ext_set = '0; bf_set = 5'd31;
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R2");

    // R5: requalification during extension reloads it
    ext_set = 4'd6; bf_set = 5'd31;
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R5");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R5");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R5");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, "R5");

    // R9: count saturates under a long overcurrent hold
    ext_set = 4'd2; bf_set = 5'd31;
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R9");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, "R9");

    // R6: overcurrent alone never starts the timer
    ext_set = 4'd3; bf_set = 5'd1;
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R6");

    // R10: no strobe, no change
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R10");
    @(negedge clk);
    trip_in = 1'b0; oc_pick = 1'b0;
    repeat (12) @(negedge clk);
    compare("R10");

    // R10: reset in mid-run clears everything
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R10");
    step(1'b0, 1'b1, "R10");
    do_reset();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule